// File: doc/BRIEF.md
# Memory Read Latency Calibrator

This block sits between an address generator and an external memory whose read latency is fixed but not known when the chip is designed. After a start pulse it watches the address-valid strobe of the generator and the data-valid strobe that the user logic raises when memory data returns. The number of cycles between the first address-valid cycle and the first rising edge of data-valid is the measured latency. The block locks that value and holds it until the next start pulse.

Once the value is locked, the block delays the control tags that travel with each address by exactly that many cycles. The tags are a pass index and a last-element flag. Each tag then arrives in the same cycle as the memory word it belongs to. The twiddle stream and the data stream share one latency value, so a single delay line serves both. If no rising edge of data-valid arrives within the supported window, the block raises a sticky timeout flag. The memory and the arithmetic datapath sit outside this block.

Top module: `lat_calibrator`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `locked`, `timeoutErr`, `tagValidOut`, `lastOut`, `passOut` and `latency` are all zero.
- R2: After a start pulse, the measured latency is the number of cycles from the first cycle with `addrValid` high to the first cycle in which `dataValid` is high after being low in the previous cycle. From the next clock edge on, `locked` is 1 and `latency` holds that value.
- R3: Any latency from 1 to 15 inclusive is measured and locked correctly. A rising edge of `dataValid` exactly 15 cycles after the first address still locks.
- R4: If `dataValid` does not rise in cycles 1 to 15 after the first address, `timeoutErr` goes to 1 at the following edge. It stays 1 and `locked` stays 0 until the next start pulse, even if `dataValid` rises later.
- R5: In the cycle of the measured rise, and in every cycle while `locked` is 1, the outputs `tagValidOut`, `lastOut` and `passOut` equal `addrValid`, `lastIn` and `passIn` from exactly `latency` cycles earlier. When `tagValidOut` is 0, `lastOut` and `passOut` are 0.
- R6: While locked, further changes or edges on `dataValid` do not change `latency` or `locked`.
- R7: A start pulse clears `locked`, `timeoutErr` and `latency` at the next edge, whatever the state was, and restarts the measurement. This includes a start in the middle of a measurement. An `addrValid` in the same cycle as the start pulse does not begin the count.
- R8: A rising edge of `dataValid` after a start but before the first `addrValid` is ignored.
- R9: Before the first start pulse after reset, `addrValid` and `dataValid` have no effect: `locked`, `timeoutErr` and `tagValidOut` stay 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| startPulse | input | 1 | One-cycle pulse that clears the state and arms the measurement |
| addrValid | input | 1 | Address-valid strobe from the address generator |
| dataValid | input | 1 | Strobe from the user logic marking returned memory data |
| passIn | input | PASS_W | Pass index that goes with the current address |
| lastIn | input | 1 | Last-element flag that goes with the current address |
| tagValidOut | output | 1 | Delayed address-valid, aligned with the returned data |
| passOut | output | PASS_W | Delayed pass index |
| lastOut | output | 1 | Delayed last-element flag |
| latency | output | 4 | Locked latency in cycles, 0 when not locked |
| locked | output | 1 | Latency has been measured and is held |
| timeoutErr | output | 1 | Sticky: no data-valid rise arrived within the window |

## Verification
The tag outputs are combinational from the delay line and the current `dataValid`. They are due in the same cycle as the matching data-valid rise, or `latency` cycles after the address once locked. `locked`, `latency` and `timeoutErr` change one edge after the rise, the 15th count cycle or the start pulse. The bench drives inputs just after the falling edge and compares every output against its reference model 1 ns later, in each cycle. Its model then steps on the rising edge. Registered results named by the requirements are probed again 2 ns after the rising edge that should have updated them.

// File: rtl/cal_pkg.sv
package cal_pkg;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned DEPTH   = 1 << SEL_W;
  localparam int unsigned MAX_LAT = DEPTH - 1;

  typedef enum logic [2:0] {
    S_IDLE,
    S_ARMED,
    S_COUNT,
    S_LOCKED,
    S_TIMEOUT
  } calState_e;

  // strobes from control to the tag datapath
  typedef struct packed {
    logic             tapEn;
    logic [SEL_W-1:0] tapSel;
  } tapCtl_t;
endpackage

// File: rtl/cal_rise_det.sv
module cal_rise_det (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic rise
);
  logic prevQ;

  always_ff @(posedge clk) begin
    if (!rstN) prevQ <= 1'b0;
    else       prevQ <= din;
  end

  assign rise = din & ~prevQ;
endmodule

// File: rtl/cal_ctrl.sv
module cal_ctrl
  import cal_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             addrValid,
  input  logic             dataRise,
  output tapCtl_t          tapCtl,
  output logic [SEL_W-1:0] latency,
  output logic             locked,
  output logic             timeoutErr
);
  localparam logic [SEL_W-1:0] MAX_SEL = SEL_W'(MAX_LAT);

  calState_e        state;
  logic [SEL_W-1:0] cnt;
  logic [SEL_W-1:0] latReg;
  logic             capture;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= S_IDLE;
      cnt    <= '0;
      latReg <= '0;
    end else if (startPulse) begin
      state  <= S_ARMED;
      cnt    <= '0;
      latReg <= '0;
    end else begin
      case (state)
        S_ARMED: begin
          if (addrValid) begin
            state <= S_COUNT;
            cnt   <= SEL_W'(1);
          end
        end
        S_COUNT: begin
          if (dataRise) begin
            state  <= S_LOCKED;
            latReg <= cnt;
          end else if (cnt == MAX_SEL) begin
            state <= S_TIMEOUT;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // the capture cycle already uses the running count as the tap
  assign capture       = (state == S_COUNT) && dataRise;
  assign locked        = (state == S_LOCKED);
  assign timeoutErr    = (state == S_TIMEOUT);
  assign latency       = latReg;
  assign tapCtl.tapEn  = locked | capture;
  assign tapCtl.tapSel = locked ? latReg : cnt;
endmodule

// File: rtl/cal_tag_delay.sv
module cal_tag_delay
  import cal_pkg::*;
#(
  parameter int unsigned PASS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              addrValid,
  input  logic [PASS_W-1:0] passIn,
  input  logic              lastIn,
  input  tapCtl_t           tapCtl,
  output logic              tagValidOut,
  output logic [PASS_W-1:0] passOut,
  output logic              lastOut
);
  localparam int unsigned ENT_W = PASS_W + 2;

  logic [ENT_W-1:0] line [1:DEPTH-1];
  logic [ENT_W-1:0] head;
  logic [ENT_W-1:0] picked;
  logic             hit;

  assign head = {addrValid, lastIn, passIn};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int k = 1; k < DEPTH; k++) line[k] <= '0;
    end else begin
      line[1] <= head;
      for (int k = 2; k < DEPTH; k++) line[k] <= line[k-1];
    end
  end

  always_comb begin
    picked = '0;
    for (int k = 1; k < DEPTH; k++) begin
      if (tapCtl.tapSel == SEL_W'(k)) picked = line[k];
    end
  end

  assign hit         = tapCtl.tapEn & picked[ENT_W-1];
  assign tagValidOut = hit;
  assign lastOut     = hit & picked[PASS_W];
  assign passOut     = hit ? picked[PASS_W-1:0] : '0;
endmodule

// File: rtl/lat_calibrator.sv
module lat_calibrator
  import cal_pkg::*;
#(
  parameter int unsigned PASS_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic              addrValid,
  input  logic              dataValid,
  input  logic [PASS_W-1:0] passIn,
  input  logic              lastIn,
  output logic              tagValidOut,
  output logic [PASS_W-1:0] passOut,
  output logic              lastOut,
  output logic [SEL_W-1:0]  latency,
  output logic              locked,
  output logic              timeoutErr
);
  logic    dataRise;
  tapCtl_t tapCtl;

  cal_rise_det u_rise (
    .clk  (clk),
    .rstN (rstN),
    .din  (dataValid),
    .rise (dataRise)
  );

  cal_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .addrValid  (addrValid),
    .dataRise   (dataRise),
    .tapCtl     (tapCtl),
    .latency    (latency),
    .locked     (locked),
    .timeoutErr (timeoutErr)
  );

  cal_tag_delay #(.PASS_W(PASS_W)) u_delay (
    .clk         (clk),
    .rstN        (rstN),
    .addrValid   (addrValid),
    .passIn      (passIn),
    .lastIn      (lastIn),
    .tapCtl      (tapCtl),
    .tagValidOut (tagValidOut),
    .passOut     (passOut),
    .lastOut     (lastOut)
  );
endmodule

// File: rtl/cal_checker.sv
module cal_checker
  import cal_pkg::*;
#(
  parameter int unsigned PASS_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              startPulse,
  input logic              dataValid,
  input logic              tagValidOut,
  input logic [PASS_W-1:0] passOut,
  input logic              lastOut,
  input logic [SEL_W-1:0]  latency,
  input logic              locked,
  input logic              timeoutErr
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rstN |=> (!locked && !timeoutErr && latency == '0));

  p_latency_range_r3: assert property (@(posedge clk) disable iff (!rstN)
    locked |-> (latency >= SEL_W'(1) && latency <= SEL_W'(MAX_LAT)));

  p_timeout_unlocked_r4: assert property (@(posedge clk) disable iff (!rstN)
    timeoutErr |-> (!locked && latency == '0));

  p_timeout_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (timeoutErr && !startPulse) |=> timeoutErr);

  p_tag_zero_r5: assert property (@(posedge clk) disable iff (!rstN)
    !tagValidOut |-> (passOut == '0 && !lastOut));

  p_tag_when_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    tagValidOut |-> (locked || dataValid));

  p_latency_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    (locked && !startPulse) |=> (locked && $stable(latency)));

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    startPulse |=> (!locked && !timeoutErr && latency == '0));
endmodule

bind lat_calibrator cal_checker #(.PASS_W(PASS_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .startPulse  (startPulse),
  .dataValid   (dataValid),
  .tagValidOut (tagValidOut),
  .passOut     (passOut),
  .lastOut     (lastOut),
  .latency     (latency),
  .locked      (locked),
  .timeoutErr  (timeoutErr)
);

// File: tb/sim_lat_calibrator.sv
module sim_lat_calibrator;
  localparam int PW = 3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startPulse = 1'b0;
  logic          addrValid = 1'b0;
  logic          dataValid = 1'b0;
  logic [PW-1:0] passIn = '0;
  logic          lastIn = 1'b0;
  logic          tagValidOut, lastOut, locked, timeoutErr;
  logic [PW-1:0] passOut;
  logic [3:0]    latency;

  int checks = 0;
  int errors = 0;
  string curReq = "R1";

  // reference model state
  int mState = 0;  // 0 idle, 1 armed, 2 counting, 3 locked, 4 timeout
  int mCnt = 0;
  int mLat = 0;
  bit mPrevDv = 0;
  logic [PW+1:0] hist[$];

  always #4 clk = ~clk;

  lat_calibrator #(.PASS_W(PW)) u0 (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .addrValid(addrValid),
    .dataValid(dataValid), .passIn(passIn), .lastIn(lastIn),
    .tagValidOut(tagValidOut), .passOut(passOut), .lastOut(lastOut),
    .latency(latency), .locked(locked), .timeoutErr(timeoutErr)
  );

  task automatic chk(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic clearHist();
    hist.delete();
    for (int i = 0; i < 16; i++) hist.push_back('0);
  endtask

  // one clock cycle: drive, compare, then step the model
  task automatic cyc(bit st, bit av, bit dv, int pass, bit last);
    bit rise, cap, en;
    int sel;
    logic [PW+1:0] ent;
    logic [10:0] expV, actV;
    @(negedge clk);
    startPulse = st; addrValid = av; dataValid = dv;
    passIn = PW'(pass); lastIn = last;
    #1;
    if (rstN) begin
      rise = dv && !mPrevDv;
      cap = (mState == 2) && rise;
      sel = (mState == 3) ? mLat : mCnt;
      en = (mState == 3) || cap;
      ent = (sel >= 1) ? hist[sel-1] : '0;
      expV[10] = en && ent[PW+1];
      expV[9] = expV[10] && ent[PW];
      expV[8:6] = expV[10] ? ent[PW-1:0] : '0;
      expV[5] = (mState == 3);
      expV[4] = (mState == 4);
      expV[3:0] = (mState == 3) ? 4'(mLat) : 4'd0;
      actV = {tagValidOut, lastOut, passOut, locked, timeoutErr, latency};
      chk(actV === expV, curReq, int'(actV), int'(expV));
    end
    @(posedge clk);
    rise = dv && !mPrevDv;
    mPrevDv = dv;
    hist.push_front({av, last, PW'(pass)});
    void'(hist.pop_back());
    if (!rstN) begin
      mState = 0; mCnt = 0; mLat = 0; mPrevDv = 0; clearHist();
    end else if (st) begin
      mState = 1; mCnt = 0; mLat = 0;
    end else begin
      case (mState)
        1: if (av) begin mState = 2; mCnt = 1; end
        2: begin
          if (rise) begin mState = 3; mLat = mCnt; end
          else if (mCnt == 15) mState = 4;
          else mCnt++;
        end
        default: ;
      endcase
    end
  endtask

  // read registered outputs shortly after the edge
  task automatic probe(string req, bit expLock, bit expTo, int expLat);
    #2;
    chk(locked === expLock, req, locked, expLock);
    chk(timeoutErr === expTo, req, timeoutErr, expTo);
    chk(latency === 4'(expLat), req, latency, expLat);
  endtask

  // address train of n cycles, data valid mirrored L cycles later
  task automatic runLat(int lat, int n, int gapEvery);
    bit avArr[$];
    for (int i = 0; i < n + lat + 2; i++) begin
      bit a, d;
      a = (i < n) && !(gapEvery > 0 && i > 0 && (i % gapEvery) == 0);
      d = (i >= lat) && avArr[i-lat];
      avArr.push_back(a);
      cyc(0, a, d, i, i == n - 1);
    end
  endtask

  initial begin
    #(8 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    clearHist();
    // R1: reset state
    curReq = "R1";
    rstN = 1'b0;
    repeat (3) cyc(0, 1, 1, 5, 1);
    rstN = 1'b1;
    cyc(0, 0, 0, 0, 0);
    probe("R1", 0, 0, 0);
    chk(tagValidOut === 1'b0, "R1", tagValidOut, 0);

    // R9: traffic before any start
    curReq = "R9";
    for (int i = 0; i < 10; i++) cyc(0, 1, i % 2, i, 0);
    probe("R9", 0, 0, 0);

    // R2 / R5: measure 4, tags aligned
    curReq = "R5";
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    runLat(4, 20, 0);
    probe("R2", 1, 0, 4);

    // R6: gaps make data-valid toggle, latency held
    curReq = "R6";
    runLat(4, 30, 5);
    probe("R6", 1, 0, 4);

    // R8: data-valid rise before first address ignored
    curReq = "R8";
    cyc(1, 0, 0, 0, 0);
    cyc(0, 0, 1, 0, 0);
    cyc(0, 0, 0, 0, 0);
    runLat(6, 12, 0);
    probe("R8", 1, 0, 6);

    // R7: start with address in the same cycle, then restart mid-count
    curReq = "R7";
    cyc(1, 1, 0, 7, 0);
    probe("R7", 0, 0, 0);
    cyc(0, 0, 0, 0, 0);
    cyc(0, 1, 0, 1, 0);
    cyc(0, 1, 0, 2, 0);
    cyc(1, 1, 0, 3, 0);
    probe("R7", 0, 0, 0);
    runLat(3, 10, 0);
    probe("R7", 1, 0, 3);

    // R3: both ends of the range
    curReq = "R3";
    cyc(1, 0, 0, 0, 0);
    runLat(15, 20, 0);
    probe("R3", 1, 0, 15);
    cyc(1, 0, 0, 0, 0);
    runLat(1, 10, 3);
    probe("R3", 1, 0, 1);

    // R4: timeout, late rise ignored, start clears it
    curReq = "R4";
    cyc(1, 0, 0, 0, 0);
    for (int i = 0; i < 15; i++) cyc(0, 1, 0, i, 0);
    probe("R4", 0, 0, 0);
    cyc(0, 1, 0, 0, 0);
    probe("R4", 0, 1, 0);
    for (int i = 0; i < 6; i++) cyc(0, 1, i > 2, i, 0);
    probe("R4", 0, 1, 0);
    curReq = "R7";
    cyc(1, 0, 0, 0, 0);
    probe("R7", 0, 0, 0);
    runLat(2, 8, 0);
    probe("R7", 1, 0, 2);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule